// File: doc/BRIEF.md
# SDRAM Bank Command Timing Checker

This block watches the command lines between a memory controller and a four-bank SDRAM device. It keeps its own picture of each bank: whether a row is open, and how many clocks have passed since the last activate, precharge and write to that bank. It also tracks how long ago an activate went to any bank. From that picture it tells the controller, before the edge, which commands may legally be issued to the bank that the bank-select lines name right now. After the edge it reports whether the command just sampled broke a spacing rule, and which rule.

Every minimum spacing is a parameter counted in clocks. The defaults match a 10 ns clock: two clocks from activate to column command, two clocks of precharge, five clocks of row active time, seven clocks of row cycle, two clocks between activates to different banks, and two clocks of write recovery. A commanded row that stays open for the maximum active time (10000 clocks by default) raises a per-bank level flag. The address lines carry nothing that the timing rules depend on, so the block does not take them.

Top module: `sdram_tcheck`

## Requirements
- R1: With cs_n low, the levels of {ras_n, cas_n, we_n} sampled at the rising edge select the command: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, anything else no-operation. With cs_n high, nothing is sampled: there is no violation and no bank state changes.
- R2: A read or write to a bank with no open row, or an activate to a bank with an open row, is flagged with code 7 (illegal state). This check comes before every timing check.
- R3: A read or write needs at least T_RCD (default 2) clocks since the activate to the same bank; a shorter gap is flagged with code 1.
- R4: An activate needs at least T_RP (default 2) clocks since the precharge of the same bank; a shorter gap is flagged with code 2.
- R5: A precharge to an open bank needs at least T_RAS (default 5) clocks since its activate, otherwise code 3. A precharge to a bank with no open row is legal and changes nothing.
- R6: An activate needs at least T_RC clocks since the previous activate to the same bank; a shorter gap is flagged with code 4. For an activate, the order of checks is code 7, 2, 4, 5.
- R7: An activate needs at least T_RRD (default 2) clocks since the last accepted activate to any bank; a shorter gap is flagged with code 5.
- R8: A precharge needs at least T_WR (default 2) clocks since the last write to the same bank; a shorter gap is flagged with code 6. Code 3 takes priority over code 6.
- R9: Reads and writes to an open bank whose T_RCD has elapsed are legal on every clock, back to back, in any mix.
- R10: A flagged command changes no bank state and does not restart any counter. Refresh, mode set and no-operation never raise a violation and change no state.
- R11: ok_act, ok_rd, ok_wr and ok_pre are combinational. Each one is high exactly when that command, issued now to the bank on ba, would not be flagged.
- R12: viol and viol_code are registered. They show the result for the command sampled at the previous rising edge. viol_code is 0 when there is no violation.
- R13: ras_over[b] is high while bank b has had an open row for at least T_RAS_MAX (default 10000) clocks since its activate. It drops once the row is precharged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| ok_act | output | 1 | Activate to bank ba would be legal now |
| ok_rd | output | 1 | Read to bank ba would be legal now |
| ok_wr | output | 1 | Write to bank ba would be legal now |
| ok_pre | output | 1 | Precharge to bank ba would be legal now |
| viol | output | 1 | Previous sampled command broke a rule |
| viol_code | output | 3 | Rule broken: 0 none, 1 row-to-column, 2 precharge period, 3 active time, 4 row cycle, 5 row-to-row, 6 write recovery, 7 illegal state |
| ras_over | output | 2**BA_W (4) | Per-bank flag: row open for the maximum active time |

## Verification
The row-cycle rule is the hardest case to reach. With the default limits it is implied by the active-time and precharge rules, because flagged commands change no state, so no legal sequence can break it. The bench therefore builds a second instance with a longer row cycle and drives activate, precharge at the active-time minimum, and activate at the precharge minimum, which falls short of the longer row cycle. The maximum-active-time flag is reached with a run of ten thousand no-operations, and is checked on both sides of the boundary clock.

// File: rtl/sdram_tc_pkg.sv
package sdram_tc_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5,
      CMD_MRS = 3'd6
   } cmd_e;

   typedef enum logic [2:0] {
      VC_NONE  = 3'd0,
      VC_RCD   = 3'd1,
      VC_RP    = 3'd2,
      VC_RAS   = 3'd3,
      VC_RC    = 3'd4,
      VC_RRD   = 3'd5,
      VC_WR    = 3'd6,
      VC_STATE = 3'd7
   } vcode_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_tc_decode.sv
module sdram_tc_decode
   import sdram_tc_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd_o
);

   always_comb begin
      cmd_o = CMD_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b010:  cmd_o = CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            3'b000:  cmd_o = CMD_MRS;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdram_tc_age.sv
module sdram_tc_age #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] age_o
);

   localparam logic [W-1:0] AGE_TOP = '1;

   initial begin
      if (W < 2) $error("sdram_tc_age: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                age_o <= AGE_TOP;
      else if (restart)          age_o <= W'(1);
      else if (age_o != AGE_TOP) age_o <= age_o + 1'b1;
   end

endmodule

// File: rtl/sdram_tc_bank.sv
module sdram_tc_bank #(
   parameter int CW        = 14,
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_RAS     = 5,
   parameter int T_RC      = 7,
   parameter int T_WR      = 2,
   parameter int T_RAS_MAX = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic pre_i,
   output logic open_o,
   output logic rcd_met_o,
   output logic rp_met_o,
   output logic ras_met_o,
   output logic rc_met_o,
   output logic wr_met_o,
   output logic over_o
);

   localparam logic [CW-1:0] LIM_RCD = CW'(T_RCD);
   localparam logic [CW-1:0] LIM_RP  = CW'(T_RP);
   localparam logic [CW-1:0] LIM_RAS = CW'(T_RAS);
   localparam logic [CW-1:0] LIM_RC  = CW'(T_RC);
   localparam logic [CW-1:0] LIM_WR  = CW'(T_WR);
   localparam logic [CW-1:0] LIM_MAX = CW'(T_RAS_MAX);
   localparam bit RC_BINDS = (T_RC > T_RAS + T_RP);

   logic          open_q;
   logic [CW-1:0] since_act;
   logic [CW-1:0] since_pre;
   logic [CW-1:0] since_wr;

   always_ff @(posedge clk) begin
      if (!rst_n)     open_q <= 1'b0;
      else if (act_i) open_q <= 1'b1;
      else if (pre_i) open_q <= 1'b0;
   end

   sdram_tc_age #(.W(CW)) u_age_act (
      .clk(clk), .rst_n(rst_n), .restart(act_i), .age_o(since_act)
   );
   sdram_tc_age #(.W(CW)) u_age_pre (
      .clk(clk), .rst_n(rst_n), .restart(pre_i), .age_o(since_pre)
   );
   sdram_tc_age #(.W(CW)) u_age_wr (
      .clk(clk), .rst_n(rst_n), .restart(wr_i), .age_o(since_wr)
   );

   assign open_o    = open_q;
   assign rcd_met_o = (since_act >= LIM_RCD);
   assign rp_met_o  = (since_pre >= LIM_RP);
   assign ras_met_o = (since_act >= LIM_RAS);
   assign wr_met_o  = (since_wr >= LIM_WR);
   assign over_o    = open_q && (since_act >= LIM_MAX);

   // The row-cycle counter check is only built when it can bind; otherwise
   // active time plus precharge period already covers it.
   if (RC_BINDS) begin : g_rc_check
      assign rc_met_o = (since_act >= LIM_RC);
   end else begin : g_rc_implied
      assign rc_met_o = 1'b1;
   end

   AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i || wr_i) |-> open_q); // R2
   AST_ACT_NEEDS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> !open_q); // R2
   AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i || wr_i) |-> (since_act >= LIM_RCD)); // R3
   AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> (since_pre >= LIM_RP)); // R4
   AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      pre_i |-> (open_q && since_act >= LIM_RAS)); // R5
   AST_ACT_AFTER_RC: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> (since_act >= LIM_RC)); // R6
   AST_PRE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      pre_i |-> (since_wr >= LIM_WR)); // R8
   AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> open_q); // R10

endmodule

// File: rtl/sdram_tcheck.sv
module sdram_tcheck
   import sdram_tc_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_RAS     = 5,
   parameter int T_RC      = 7,
   parameter int T_RRD     = 2,
   parameter int T_WR      = 2,
   parameter int T_RAS_MAX = 10000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BA_W-1:0]        ba,
   output logic                   ok_act,
   output logic                   ok_rd,
   output logic                   ok_wr,
   output logic                   ok_pre,
   output logic                   viol,
   output logic [2:0]             viol_code,
   output logic [(1<<BA_W)-1:0]   ras_over
);

   localparam int NB   = 1 << BA_W;
   localparam int TTOP = imax(imax(imax(T_RCD, T_RP), imax(T_RAS, T_RC)),
                              imax(imax(T_RRD, T_WR), T_RAS_MAX));
   localparam int CW   = $clog2(TTOP + 2);
   localparam logic [CW-1:0] LIM_RRD = CW'(T_RRD);

   if (BA_W < 1 || BA_W > 3) begin : g_bad_ba
      $error("sdram_tcheck: BA_W out of range");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RAS < 1 || T_RC < 1 || T_RRD < 1 || T_WR < 1) begin : g_bad_t
      $error("sdram_tcheck: every spacing limit must be at least one clock");
   end
   if (T_RAS_MAX <= T_RAS) begin : g_bad_max
      $error("sdram_tcheck: maximum active time must exceed the minimum");
   end

   cmd_e   cmd;
   vcode_e code_act, code_col, code_pre, code_cur;
   vcode_e code_q;
   logic   viol_q;
   logic   accept;
   logic   issue_act, issue_rd, issue_wr, issue_pre;

   logic [NB-1:0] open_v, rcd_v, rp_v, ras_v, rc_v, wr_v, over_v;
   logic          open_s, rcd_s, rp_s, ras_s, rc_s, wr_s;
   logic [CW-1:0] since_any_act;
   logic          rrd_met;

   sdram_tc_decode u_decode (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_o(cmd)
   );

   sdram_tc_age #(.W(CW)) u_age_rrd (
      .clk(clk), .rst_n(rst_n), .restart(issue_act), .age_o(since_any_act)
   );
   assign rrd_met = (since_any_act >= LIM_RRD);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(b));
      sdram_tc_bank #(
         .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
         .T_RC(T_RC), .T_WR(T_WR), .T_RAS_MAX(T_RAS_MAX)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .act_i(issue_act && hit), .rd_i(issue_rd && hit),
         .wr_i(issue_wr && hit),   .pre_i(issue_pre && hit),
         .open_o(open_v[b]), .rcd_met_o(rcd_v[b]), .rp_met_o(rp_v[b]),
         .ras_met_o(ras_v[b]), .rc_met_o(rc_v[b]), .wr_met_o(wr_v[b]),
         .over_o(over_v[b])
      );
   end

   assign open_s = open_v[ba];
   assign rcd_s  = rcd_v[ba];
   assign rp_s   = rp_v[ba];
   assign ras_s  = ras_v[ba];
   assign rc_s   = rc_v[ba];
   assign wr_s   = wr_v[ba];

   always_comb begin
      if (open_s)        code_act = VC_STATE;
      else if (!rp_s)    code_act = VC_RP;
      else if (!rc_s)    code_act = VC_RC;
      else if (!rrd_met) code_act = VC_RRD;
      else               code_act = VC_NONE;

      if (!open_s)       code_col = VC_STATE;
      else if (!rcd_s)   code_col = VC_RCD;
      else               code_col = VC_NONE;

      if (!open_s)       code_pre = VC_NONE;
      else if (!ras_s)   code_pre = VC_RAS;
      else if (!wr_s)    code_pre = VC_WR;
      else               code_pre = VC_NONE;

      unique case (cmd)
         CMD_ACT:        code_cur = code_act;
         CMD_RD, CMD_WR: code_cur = code_col;
         CMD_PRE:        code_cur = code_pre;
         default:        code_cur = VC_NONE;
      endcase
   end

   assign accept    = (code_cur == VC_NONE);
   assign issue_act = accept && (cmd == CMD_ACT);
   assign issue_rd  = accept && (cmd == CMD_RD);
   assign issue_wr  = accept && (cmd == CMD_WR);
   assign issue_pre = accept && (cmd == CMD_PRE) && open_s;

   assign ok_act = (code_act == VC_NONE);
   assign ok_rd  = (code_col == VC_NONE);
   assign ok_wr  = (code_col == VC_NONE);
   assign ok_pre = (code_pre == VC_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_q <= 1'b0;
         code_q <= VC_NONE;
      end else begin
         viol_q <= !accept;
         code_q <= code_cur;
      end
   end

   assign viol      = viol_q;
   assign viol_code = code_q;
   assign ras_over  = over_v;

   AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> !viol); // R1
   AST_VIOL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> $past(cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_PRE)); // R12
   AST_ACT_AFTER_RRD: assert property (@(posedge clk) disable iff (!rst_n)
      issue_act |-> (since_any_act >= LIM_RRD)); // R7
   AST_ONE_BANK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(open_v ^ $past(open_v)) <= 1); // R10

endmodule

// File: tb/sdram_tcheck_bench.sv
`timescale 1ns/1ps
module sdram_tcheck_bench;

   localparam logic [2:0] C_ACT = 3'b011;
   localparam logic [2:0] C_RD  = 3'b101;
   localparam logic [2:0] C_WR  = 3'b100;
   localparam logic [2:0] C_PRE = 3'b010;
   localparam logic [2:0] C_REF = 3'b001;
   localparam logic [2:0] C_MRS = 3'b000;
   localparam logic [2:0] C_NOP = 3'b111;

   typedef struct {
      logic [2:0] code;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = 2'd0;
   logic       ok_act, ok_rd, ok_wr, ok_pre, viol;
   logic [2:0] viol_code;
   logic [3:0] ras_over;

   logic       cs2_n = 1'b1, ras2_n = 1'b1, cas2_n = 1'b1, we2_n = 1'b1;
   logic [1:0] ba2 = 2'd0;
   logic       ok_act2, ok_rd2, ok_wr2, ok_pre2, viol2;
   logic [2:0] code2;
   logic [3:0] over2;

   int   n_vec = 0;
   int   n_bad = 0;
   int   stepn = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   sdram_tcheck u_sdram_tcheck (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr),
      .ok_pre(ok_pre), .viol(viol), .viol_code(viol_code), .ras_over(ras_over)
   );

   sdram_tcheck #(.T_RC(9)) u_sdram_tcheck_rc (
      .clk(clk), .rst_n(rst_n), .cs_n(cs2_n), .ras_n(ras2_n), .cas_n(cas2_n),
      .we_n(we2_n), .ba(ba2), .ok_act(ok_act2), .ok_rd(ok_rd2), .ok_wr(ok_wr2),
      .ok_pre(ok_pre2), .viol(viol2), .viol_code(code2), .ras_over(over2)
   );

   task automatic chk(input bit good, input string tag, input int got, input int exp);
      n_vec++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
      end
   endtask

   // Monitor: the result of the command driven before edge k appears after edge k.
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk(viol === (e.code != 3'd0), {e.tag, " viol"}, int'(viol), int'(e.code != 3'd0));
         chk(viol_code === e.code, {e.tag, " code"}, int'(viol_code), int'(e.code));
      end
   end

   // Driver: one command per clock, expected result pushed to the scoreboard.
   task automatic step(input logic c, input logic [2:0] rcw, input logic [1:0] b,
                       input logic [2:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      cs_n = c;
      {ras_n, cas_n, we_n} = rcw;
      ba = b;
      e.code = exp;
      e.tag  = tag;
      sb_q.push_back(e);
      #1;
      if (!c) begin
         case (rcw)
            C_ACT: chk(ok_act === (exp == 3'd0), {tag, " ok_act R11"}, int'(ok_act), int'(exp == 3'd0));
            C_RD:  chk(ok_rd  === (exp == 3'd0), {tag, " ok_rd R11"},  int'(ok_rd),  int'(exp == 3'd0));
            C_WR:  chk(ok_wr  === (exp == 3'd0), {tag, " ok_wr R11"},  int'(ok_wr),  int'(exp == 3'd0));
            C_PRE: chk(ok_pre === (exp == 3'd0), {tag, " ok_pre R11"}, int'(ok_pre), int'(exp == 3'd0));
            default: ;
         endcase
      end
      stepn++;
   endtask

   task automatic step2(input logic [2:0] rcw, input logic [1:0] b,
                        input logic [2:0] exp, input string tag);
      @(negedge clk);
      cs2_n = 1'b0;
      {ras2_n, cas2_n, we2_n} = rcw;
      ba2 = b;
      @(posedge clk);
      #1;
      chk(code2 === exp, tag, int'(code2), int'(exp));
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // Reset state (R12, R13, R11)
      chk(viol === 1'b0,      "reset viol R12",     int'(viol), 0);
      chk(viol_code === 3'd0, "reset code R12",     int'(viol_code), 0);
      chk(ras_over === 4'd0,  "reset ras_over R13", int'(ras_over), 0);
      chk(ok_act === 1'b1,    "reset ok_act R11",   int'(ok_act), 1);
      chk(ok_rd === 1'b0,     "reset ok_rd R11",    int'(ok_rd), 0);
      chk(ok_pre === 1'b1,    "reset ok_pre R5",    int'(ok_pre), 1);

      step(1'b0, C_RD,  2'd0, 3'd7, "s0 read closed R2");          // 0
      step(1'b0, C_ACT, 2'd0, 3'd0, "s1 act b0 R1");                // 1
      step(1'b0, C_ACT, 2'd1, 3'd5, "s2 act b1 early R7");          // 2
      step(1'b0, C_ACT, 2'd1, 3'd0, "s3 act b1 R7 R10");            // 3
      step(1'b0, C_WR,  2'd1, 3'd1, "s4 write early R3");           // 4
      step(1'b0, C_WR,  2'd1, 3'd0, "s5 write at limit R3");        // 5
      step(1'b0, C_PRE, 2'd1, 3'd3, "s6 pre early R5 over R8");     // 6
      step(1'b0, C_PRE, 2'd1, 3'd3, "s7 pre early R5");             // 7
      step(1'b0, C_PRE, 2'd1, 3'd0, "s8 pre at limit R5");          // 8
      step(1'b0, C_ACT, 2'd1, 3'd2, "s9 act early R4 over R6");     // 9
      step(1'b0, C_ACT, 2'd1, 3'd0, "s10 act at limit R4");         // 10
      step(1'b0, C_ACT, 2'd1, 3'd7, "s11 act open R2 over R7");     // 11
      step(1'b0, C_RD,  2'd0, 3'd0, "s12 read b0 R9");              // 12
      step(1'b0, C_NOP, 2'd0, 3'd0, "s13 nop R10");                 // 13
      step(1'b0, C_NOP, 2'd0, 3'd0, "s14 nop R10");                 // 14
      step(1'b0, C_WR,  2'd1, 3'd0, "s15 write b1 R9");             // 15
      step(1'b0, C_PRE, 2'd1, 3'd6, "s16 pre early R8");            // 16
      step(1'b0, C_PRE, 2'd1, 3'd0, "s17 pre at limit R8");         // 17
      step(1'b1, C_PRE, 2'd0, 3'd0, "s18 cs high R1");              // 18
      step(1'b0, C_RD,  2'd0, 3'd0, "s19 b0 still open R1");        // 19
      step(1'b0, C_REF, 2'd0, 3'd0, "s20 refresh R10");             // 20
      step(1'b0, C_MRS, 2'd2, 3'd0, "s21 mode set R10");            // 21
      step(1'b0, C_RD,  2'd0, 3'd0, "s22 read R9");                 // 22
      step(1'b0, C_RD,  2'd0, 3'd0, "s23 read R9");                 // 23
      step(1'b0, C_WR,  2'd0, 3'd0, "s24 write R9");                // 24
      step(1'b0, C_WR,  2'd0, 3'd0, "s25 write R9");                // 25
      step(1'b0, C_PRE, 2'd1, 3'd0, "s26 pre closed b1 R5");        // 26
      step(1'b0, C_RD,  2'd1, 3'd7, "s27 b1 closed R5 R2");         // 27

      while (stepn <= 10000) step(1'b0, C_NOP, 2'd0, 3'd0, "idle R10");
      chk(ras_over === 4'b0000, "ras_over before limit R13", int'(ras_over), 0);
      step(1'b0, C_NOP, 2'd0, 3'd0, "idle R10");
      chk(ras_over === 4'b0001, "ras_over at limit R13", int'(ras_over), 1);
      step(1'b0, C_PRE, 2'd0, 3'd0, "pre b0 R5");
      step(1'b0, C_NOP, 2'd0, 3'd0, "idle R10");
      chk(ras_over === 4'b0000, "ras_over after pre R13", int'(ras_over), 0);
      step(1'b1, C_NOP, 2'd0, 3'd0, "quiet R1");
      repeat (3) @(posedge clk);

      // Row-cycle rule on an instance where it binds (T_RC = 9)
      step2(C_ACT, 2'd3, 3'd0, "rc: act R6");
      repeat (4) step2(C_NOP, 2'd3, 3'd0, "rc: nop R6");
      step2(C_PRE, 2'd3, 3'd0, "rc: pre R6");
      step2(C_NOP, 2'd3, 3'd0, "rc: nop R6");
      step2(C_ACT, 2'd3, 3'd4, "rc: act short cycle R6");
      step2(C_NOP, 2'd3, 3'd0, "rc: nop R6");
      step2(C_ACT, 2'd3, 3'd0, "rc: act full cycle R6");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule